// File: doc/BRIEF.md
# Oscillator Retune Sequencer with Freeze Control

This block takes a new six-byte divider/multiplier register image for a programmable crystal-referenced oscillator, together with the 38-bit multiplier value (10 integer bits, 28 fraction bits) encoded in that image. It then issues the register-write transactions that move the oscillator to the new frequency. The transactions go one at a time to an external two-wire bus master, over a command channel with valid/ready flow control. For each command the master returns a single response pulse that carries an acknowledge/not-acknowledge flag.

Before it writes anything, the block compares the new multiplier with the multiplier recorded at the most recent completed core freeze. A large step is wrapped in a freeze and release of the oscillator core. A small step is wrapped in a hold of the multiplier update, so that the output moves in one jump once all six bytes are in place. The recorded value is replaced only when a freeze-wrapped update finishes cleanly.

A refused write stops the update at once and raises an error flag. The flag stays set until reset.

Request channel rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the update ends, so a request offered in that window is not taken. Command channel rules: `cmd_valid` stays high with a constant payload until `cmd_ready` is seen high. Only one command is ever outstanding.

Top module: `retune_sequencer`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, `cmd_valid` is 0 and `error` is 0.
- R2: Every command carries the device byte 0xAA, which is the 7-bit address 0x55 shifted left by one with a write direction bit of 0 in bit 0.
- R3: A freeze-path update issues exactly eight commands in this order: register 137 with data 0x10 (bit 4 set), then registers 7 to 12 with the image bytes, then register 137 with data 0x00. Register 7 takes image bits [47:40] and register 12 takes bits [7:0].
- R4: A hold-path update issues exactly eight commands in this order: register 135 with data 0x20 (bit 5 set), then registers 7 to 12 with the image bytes, then register 135 with data 0x00.
- R5: The freeze path is taken when the absolute difference between the new multiplier and the recorded one is greater than 39,460,012 (0.147 in units of 2^-28). A difference equal to the threshold, or smaller, takes the hold path. The rule applies in both directions.
- R6: The first update after reset always takes the freeze path.
- R7: The recorded multiplier is replaced by the new one only when a freeze-path update receives an acknowledge on its final command. A hold-path update leaves it unchanged.
- R8: A not-acknowledge response ends the update with no further commands. It sets `error`, which stays at 1 until reset, and leaves the recorded multiplier unchanged.
- R9: `busy` is 1 from the cycle after a request is taken until the cycle after the final response. `req_ready` is low throughout, so a request offered and withdrawn in that window produces no commands.
- R10: After a command handshake, `cmd_valid` stays low until that command's response has arrived.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_reg` and `cmd_data` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New retune request offered |
| req_ready | output | 1 | Block can take a request |
| req_image | input | 48 | Register image, byte for register 7 in the top byte |
| req_mult | input | 38 | Multiplier in 10.28 fixed point |
| cmd_valid | output | 1 | Write command offered to the bus master |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_dev | output | 8 | Device address byte with direction bit |
| cmd_reg | output | 8 | Target register number |
| cmd_data | output | 8 | Data byte |
| rsp_valid | input | 1 | One-cycle pulse when the transaction's stop completes |
| rsp_nack | input | 1 | Transaction was not acknowledged (valid with rsp_valid) |
| busy | output | 1 | Update in progress |
| error | output | 1 | Sticky not-acknowledge flag |

## Verification
Two events can land on the same clock edge: the response to the final command and the update of the recorded multiplier. When that response is a not-acknowledge, the abort has to win and the commit must not happen. The bench provokes this by refusing the eighth command of a freeze-path update whose multiplier is far from the recorded one. It then sends a small step measured from the old recorded value. If the update expected after the abort takes the hold path, the stale value survived; a freeze path there means the aborted value was committed. The bench also offers a request while an update is running, with the command channel stalled by back-pressure, and confirms that only the original eight commands appear.

// File: rtl/retune_pkg.sv
package retune_pkg;
  localparam logic [6:0] DEV_ADDR7     = 7'h55;
  localparam logic [7:0] REG_IMG_FIRST = 8'd7;
  localparam logic [7:0] REG_CORE_FRZ  = 8'd137;
  localparam logic [7:0] REG_MULT_HOLD = 8'd135;
  localparam int         CORE_FRZ_BIT  = 4;
  localparam int         MULT_HOLD_BIT = 5;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/freeze_decider.sv
module freeze_decider #(
  parameter int          MULT_W = 38,
  parameter longint unsigned THRESH = 64'd39460012
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MULT_W-1:0] cand_mult,
  input  logic              commit,
  input  logic [MULT_W-1:0] commit_mult,
  output logic              need_freeze
);
  localparam logic [MULT_W-1:0] LIMIT = MULT_W'(THRESH);

  logic [MULT_W-1:0] last_mult;
  logic              have_last;
  logic [MULT_W-1:0] delta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_mult <= '0;
      have_last <= 1'b0;
    end else if (commit) begin
      last_mult <= commit_mult;
      have_last <= 1'b1;
    end
  end

  always_comb begin
    if (cand_mult >= last_mult) delta = cand_mult - last_mult;
    else                        delta = last_mult - cand_mult;
    need_freeze = !have_last || (delta > LIMIT);
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import retune_pkg::*;
#(
  parameter int NSTEPS = 8,
  localparam int STEP_W = $clog2(NSTEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  output logic              cmd_valid,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              done_ok,
  output logic              abort
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEPS - 1);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_ISSUE;
          step  <= '0;
        end
        SQ_ISSUE: if (cmd_ready) state <= SQ_WAIT;
        SQ_WAIT: if (rsp_valid) begin
          if (rsp_nack || step == LAST) state <= SQ_IDLE;
          else begin
            state <= SQ_ISSUE;
            step  <= step + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_valid = (state == SQ_ISSUE);
  assign busy      = (state != SQ_IDLE);
  assign done_ok   = (state == SQ_WAIT) && rsp_valid && !rsp_nack && (step == LAST);
  assign abort     = (state == SQ_WAIT) && rsp_valid && rsp_nack;
endmodule

// File: rtl/cmd_payload.sv
module cmd_payload
  import retune_pkg::*;
#(
  parameter int IMG_BYTES = 6,
  localparam int NSTEPS = IMG_BYTES + 2,
  localparam int STEP_W = $clog2(NSTEPS)
) (
  input  logic [STEP_W-1:0]      step,
  input  logic                   freeze_path,
  input  logic [IMG_BYTES*8-1:0] image,
  output logic [7:0]             reg_num,
  output logic [7:0]             data
);
  logic [7:0] img_byte [IMG_BYTES];

  for (genvar g = 0; g < IMG_BYTES; g++) begin : g_slice
    assign img_byte[g] = image[(IMG_BYTES-1-g)*8 +: 8];
  end

  logic [7:0] bracket_reg;
  logic [7:0] bracket_set;
  int         idx;

  always_comb begin
    bracket_reg = freeze_path ? REG_CORE_FRZ : REG_MULT_HOLD;
    bracket_set = freeze_path ? 8'(1 << CORE_FRZ_BIT) : 8'(1 << MULT_HOLD_BIT);
    idx         = int'(step) - 1;
    if (step == '0) begin
      reg_num = bracket_reg;
      data    = bracket_set;
    end else if (int'(step) == NSTEPS - 1) begin
      reg_num = bracket_reg;
      data    = 8'h00;
    end else begin
      reg_num = REG_IMG_FIRST + 8'(idx);
      data    = (idx >= 0 && idx < IMG_BYTES) ? img_byte[idx] : 8'h00;
    end
  end
endmodule

// File: rtl/retune_sequencer.sv
module retune_sequencer
  import retune_pkg::*;
#(
  parameter int              MULT_W    = 38,
  parameter int              IMG_BYTES = 6,
  parameter longint unsigned THRESH    = 64'd39460012
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IMG_BYTES*8-1:0] req_image,
  input  logic [MULT_W-1:0]      req_mult,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [7:0]             cmd_dev,
  output logic [7:0]             cmd_reg,
  output logic [7:0]             cmd_data,
  input  logic                   rsp_valid,
  input  logic                   rsp_nack,
  output logic                   busy,
  output logic                   error
);
  localparam int NSTEPS = IMG_BYTES + 2;
  localparam int STEP_W = $clog2(NSTEPS);

  logic [IMG_BYTES*8-1:0] img_q;
  logic [MULT_W-1:0]      mult_q;
  logic                   freeze_q;
  logic                   need_freeze;
  logic                   start;
  logic                   done_ok;
  logic                   abort;
  logic [STEP_W-1:0]      step;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  freeze_decider #(.MULT_W(MULT_W), .THRESH(THRESH)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_mult   (req_mult),
    .commit      (done_ok && freeze_q),
    .commit_mult (mult_q),
    .need_freeze (need_freeze)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q    <= '0;
      mult_q   <= '0;
      freeze_q <= 1'b0;
      error    <= 1'b0;
    end else begin
      if (start) begin
        img_q    <= req_image;
        mult_q   <= req_mult;
        freeze_q <= need_freeze;
      end
      if (abort) error <= 1'b1;
    end
  end

  seq_ctrl #(.NSTEPS(NSTEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_nack  (rsp_nack),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .step      (step),
    .done_ok   (done_ok),
    .abort     (abort)
  );

  cmd_payload #(.IMG_BYTES(IMG_BYTES)) u_payload (
    .step        (step),
    .freeze_path (freeze_q),
    .image       (img_q),
    .reg_num     (cmd_reg),
    .data        (cmd_data)
  );

  assign cmd_dev = {DEV_ADDR7, 1'b0};
endmodule

// File: rtl/retune_sequencer_checker.sv
module retune_sequencer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_dev,
  input logic [7:0] cmd_reg,
  input logic [7:0] cmd_data,
  input logic       rsp_valid,
  input logic       rsp_nack,
  input logic       busy,
  input logic       error
);
  assert_dev_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_dev == 8'hAA);

  assert_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_one_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  assert_hold_payload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_reg) && $stable(cmd_data));

  assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_valid && rsp_valid && rsp_nack |=> error && !busy);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
endmodule

bind retune_sequencer retune_sequencer_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_dev   (cmd_dev),
  .cmd_reg   (cmd_reg),
  .cmd_data  (cmd_data),
  .rsp_valid (rsp_valid),
  .rsp_nack  (rsp_nack),
  .busy      (busy),
  .error     (error)
);

// File: tb/retune_sequencer_test.sv
module retune_sequencer_test;
  localparam longint THR = 64'd39460012;
  localparam logic [37:0] A = 38'h2DE5A8555;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [47:0] req_image = '0;
  logic [37:0] req_mult = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1;
  logic [7:0]  cmd_dev, cmd_reg, cmd_data;
  logic        rsp_valid = 0;
  logic        rsp_nack = 0;
  logic        busy, error;

  always #2 clk = ~clk;

  retune_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_image(req_image), .req_mult(req_mult), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .busy(busy), .error(error)
  );

  int n_chk = 0, n_bad = 0;
  int lg_reg [16];
  int lg_dat [16];
  int lg_dev [16];
  int ntx = 0;
  int nack_at = -1;
  int rsp_delay = 1;
  bit stall = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus master model, acts on falling edges
  initial begin
    int cyc = 0, dly = 0, pidx = 0;
    bit pend = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 0;
      rsp_nack = 0;
      if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1;
          rsp_nack = (pidx == nack_at);
          pend = 0;
        end else dly--;
      end
      cmd_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (cmd_valid && cmd_ready) begin
        if (ntx < 16) begin
          lg_reg[ntx] = int'(cmd_reg);
          lg_dat[ntx] = int'(cmd_data);
          lg_dev[ntx] = int'(cmd_dev);
        end
        pend = 1;
        pidx = ntx;
        dly = rsp_delay;
        ntx++;
      end
    end
  end

  function automatic int exp_reg(int i, bit fz);
    if (i == 0 || i == 7) return fz ? 137 : 135;
    return 6 + i;
  endfunction

  function automatic int exp_dat(int i, bit fz, logic [47:0] img);
    if (i == 0) return fz ? 8'h10 : 8'h20;
    if (i == 7) return 0;
    return int'(img[(6 - i) * 8 +: 8]);
  endfunction

  task automatic check_log(input string req, input bit fz, input logic [47:0] img, input int n);
    chk(ntx == n, req, "command count", ntx, n);
    for (int i = 0; i < n && i < 16; i++) begin
      chk(lg_dev[i] == 8'hAA, "R2", "device byte", lg_dev[i], 8'hAA);
      chk(lg_reg[i] == exp_reg(i, fz), req, "register", lg_reg[i], exp_reg(i, fz));
      chk(lg_dat[i] == exp_dat(i, fz, img), req, "data", lg_dat[i], exp_dat(i, fz, img));
    end
  endtask

  task automatic run_update(input logic [47:0] img, input logic [37:0] m, input bit intrude);
    int t = 0;
    ntx = 0;
    @(negedge clk);
    req_valid = 1; req_image = img; req_mult = m;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R9", "busy after take", busy, 1);
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        req_valid = 1; req_image = ~img; req_mult = m + 38'd1;
        @(negedge clk);
        chk(req_ready == 0, "R9", "ready while busy", req_ready, 0);
      end
      req_valid = 0;
    end
    while (busy && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk(busy == 0, "R9", "busy dropped", busy, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    chk(cmd_valid == 0, "R1", "cmd_valid", cmd_valid, 0);
    chk(error == 0, "R1", "error", error, 0);
  endtask

  task automatic t_first;
    run_update(48'hE842DE5A8555, A, 0);
    check_log("R6", 1, 48'hE842DE5A8555, 8);
  endtask

  task automatic t_small;
    run_update(48'h123456789ABC, A + 38'd1000, 0);
    check_log("R4", 0, 48'h123456789ABC, 8);
  endtask

  task automatic t_edges;
    run_update(48'h0102030405F6, A + 38'(THR), 0);
    check_log("R5", 0, 48'h0102030405F6, 8);
    run_update(48'hA0B1C2D3E4F5, A + 38'(THR) + 38'd1, 0);
    check_log("R5", 1, 48'hA0B1C2D3E4F5, 8);
    run_update(48'h5566778899AA, A, 0);
    check_log("R7", 1, 48'h5566778899AA, 8);
  endtask

  task automatic t_nack_mid;
    nack_at = 3;
    run_update(48'hCAFEF00DBEEF, A + 38'(5 * THR), 0);
    nack_at = -1;
    chk(ntx == 4, "R8", "commands before abort", ntx, 4);
    chk(error == 1, "R8", "error set", error, 1);
    run_update(48'h111111111111, A + 38'd100, 0);
    check_log("R8", 0, 48'h111111111111, 8);
    chk(error == 1, "R8", "error sticky", error, 1);
  endtask

  task automatic t_nack_last;
    nack_at = 7;
    run_update(48'h222222222222, A + 38'(7 * THR), 0);
    nack_at = -1;
    check_log("R3", 1, 48'h222222222222, 8);
    run_update(48'h333333333333, A + 38'd200, 0);
    check_log("R7", 0, 48'h333333333333, 8);
  endtask

  task automatic t_stall;
    stall = 1;
    rsp_delay = 3;
    run_update(48'h0F1E2D3C4B5A, A + 38'd300, 1);
    check_log("R11", 0, 48'h0F1E2D3C4B5A, 8);
    stall = 0;
    rsp_delay = 1;
  endtask

  task automatic t_rereset;
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_update(48'h998877665544, A + 38'd1, 0);
    check_log("R6", 1, 48'h998877665544, 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first();
    t_small();
    t_edges();
    t_nack_mid();
    t_nack_last();
    t_stall();
    t_rereset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule